// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Command Sequencer

This block sits between a simple host request port and an asynchronous DRAM with a multiplexed address bus and a 4-bit data path. It drives the row strobe, column strobe, write enable, output enable, the shared address lines and the write data. Each host request carries a full row and column address, a read/write flag and write data. Reads come back on `rd_data` with a one-cycle `rd_valid` pulse. Every strobe width and delay is a count of clock cycles set by a parameter. A free-running refresh timer inserts refresh cycles in which the column strobe leads the row strobe. These cycles interrupt open pages and take priority over new host work.

The controller has nine states. ST_PRE holds both strobes high for the precharge count, then moves to ST_IDLE. ST_IDLE goes to ST_CBR_CAS when a refresh is pending. Otherwise, when a request is accepted, it goes to ST_ROW. ST_ROW puts the row on the address lines with the row strobe still high and moves to ST_RCD. ST_RCD drops the row strobe and holds the row for the row-to-column count, then moves to ST_COL. ST_COL presents the column and sets write enable for one cycle, then moves to ST_CAS. ST_CAS holds the column strobe low for the access count and captures read data on its last cycle, then moves to ST_PAGE. ST_PAGE keeps the row open with the column strobe high. It returns to ST_COL on an accepted request to the same row. It goes to ST_PRE on a pending refresh, on a request to another row, or when one more access would exceed the row-strobe limit. In ST_CBR_CAS the column strobe falls while the row strobe stays high and write enable is high; the state moves to ST_CBR_RAS. ST_CBR_RAS holds both strobes low for the refresh pulse and then moves to ST_PRE. Reset enters ST_PRE.

Top module: `fpm_dram_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `ras_n`, `cas_n`, `we_n` and `oe_n` are 1, `dq_oe`, `rd_valid` and `req_ready` are 0.
- R2: The row is on `addr` (low ROW_W bits) and stable when `ras_n` falls; the column is on `addr` (low COL_W bits) one cycle before `cas_n` falls and stays stable while both strobes are low.
- R3: A read keeps `we_n`=1, drives `oe_n`=0 while `cas_n` is low, samples `dq_in` on the last of T_CAS column-strobe cycles and returns it on `rd_data` with `rd_valid`=1 for exactly the next cycle.
- R4: A write drives `we_n`=0 and `dq_oe`=1 with `dq_out`=write data from the cycle before `cas_n` falls until `cas_n` rises (early write), and keeps `oe_n`=1.
- R5: A request to the open row while the page is open is served with `ras_n` held low: one new column strobe, no new row strobe.
- R6: A request to a different row closes the page (`ras_n` high for T_RP cycles) and runs a full row-then-column cycle.
- R7: `ras_n` stays high at least T_RP cycles before every falling edge.
- R8: `ras_n` is never low for more than T_RAS_MAX consecutive cycles; an idle open page is closed before that limit.
- R9: A refresh is requested every REF_PERIOD/(2^ROW_W+1) cycles, so any REF_PERIOD-cycle window holds at least 2^ROW_W refresh cycles.
- R10: A refresh drops `cas_n` T_CSR cycles before `ras_n`, holds both low T_RAS_CBR cycles, and keeps `we_n`=1 and `dq_oe`=0 throughout.
- R11: A pending refresh closes an open page and is served before any new request; `req_ready` is 0 while it is pending.
- R12: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1; `req_ready` is 1 only in ST_IDLE or in ST_PAGE for a row hit.
- R13: `we_n` and `oe_n` are never low together, `dq_oe` is never 1 while `oe_n` is 0, and `rd_valid` never stays high two cycles running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request is taken this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_out | output | DATA_W | Write data to memory |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | DATA_W | Read data from memory |

## Verification
A state that decodes the wrong access kind shows up within one strobe cycle. Write enable and output enable then fall together, or a refresh begins with write enable low, and the strobe-pattern checks catch this. A stale open-row or age register shows up as a row strobe falling too early after precharge or staying low past its limit. It can also show as a page hit served under the wrong row, which the read-back scoreboard detects at the next read of that location. A lost refresh request shows up only across a whole refresh window, so refresh coverage is measured over a full period of traffic.

// File: rtl/fpm_seq_pkg.sv
package fpm_seq_pkg;

    typedef enum logic [3:0] {
        ST_PRE,
        ST_IDLE,
        ST_ROW,
        ST_RCD,
        ST_COL,
        ST_CAS,
        ST_PAGE,
        ST_CBR_CAS,
        ST_CBR_RAS
    } seq_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_wait_counter.sv
module fpm_wait_counter #(
    parameter int CW        = 4,
    parameter int RESET_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CW'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
    parameter int INTERVAL = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);

    localparam int TW = $clog2(INTERVAL + 1);

    logic [TW-1:0] tick_q;
    logic          pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= TW'(INTERVAL - 1);
            pend_q <= 1'b0;
        end else begin
            if (tick_q == '0) begin
                tick_q <= TW'(INTERVAL - 1);
            end else begin
                tick_q <= tick_q - 1'b1;
            end
            // a new tick outranks an acknowledge in the same cycle
            if (tick_q == '0) begin
                pend_q <= 1'b1;
            end else if (ack) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign pending = pend_q;

endmodule

// File: rtl/fpm_dram_seq.sv
module fpm_dram_seq
    import fpm_seq_pkg::*;
#(
    parameter int ROW_W      = 13,
    parameter int COL_W      = 11,
    parameter int DATA_W     = 4,
    parameter int T_RP       = 3,
    parameter int T_RCD      = 2,
    parameter int T_CAS      = 2,
    parameter int T_CSR      = 1,
    parameter int T_RAS_CBR  = 4,
    parameter int T_RAS_MAX  = 1000,
    parameter int REF_PERIOD = 6400000,
    localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);

    localparam int ROWS         = 1 << ROW_W;
    localparam int REF_INTERVAL = REF_PERIOD / (ROWS + 1);
    localparam int WAIT_MAX     = max_int(max_int(max_int(T_RP, T_RCD),
                                                  max_int(T_CAS, T_CSR)), T_RAS_CBR);
    localparam int WCW          = $clog2(WAIT_MAX + 1);
    localparam int AGE_W        = $clog2(T_RAS_MAX + 1);
    // last row-strobe age at which one more column access still fits
    localparam int HIT_LIMIT    = T_RAS_MAX - T_CAS - 3;

    seq_state_e        state_q;
    seq_state_e        nxt;
    logic              wait_done;
    logic              wait_load;
    logic [WCW-1:0]    wait_val;
    logic              ref_pend;
    logic              ref_ack;
    logic              accept;
    logic              row_hit;
    logic              page_ok;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [AGE_W-1:0]  age_q;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;

    fpm_wait_counter #(
        .CW        (WCW),
        .RESET_VAL (T_RP - 1)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .done     (wait_done)
    );

    fpm_refresh_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pend)
    );

    assign row_hit = (req_row == row_q);
    assign page_ok = (age_q <= AGE_W'(HIT_LIMIT));

    // handshake and transitions
    always_comb begin
        req_ready = 1'b0;
        nxt       = state_q;
        unique case (state_q)
            ST_PRE: begin
                if (wait_done) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                req_ready = !ref_pend;
                if (ref_pend) begin
                    nxt = ST_CBR_CAS;
                end else if (req_valid) begin
                    nxt = ST_ROW;
                end
            end
            ST_ROW: nxt = ST_RCD;
            ST_RCD: begin
                if (wait_done) nxt = ST_COL;
            end
            ST_COL: nxt = ST_CAS;
            ST_CAS: begin
                if (wait_done) nxt = ST_PAGE;
            end
            ST_PAGE: begin
                req_ready = !ref_pend && row_hit && page_ok;
                if (req_valid && req_ready) begin
                    nxt = ST_COL;
                end else if (ref_pend || !page_ok || req_valid) begin
                    nxt = ST_PRE;
                end
            end
            ST_CBR_CAS: begin
                if (wait_done) nxt = ST_CBR_RAS;
            end
            ST_CBR_RAS: begin
                if (wait_done) nxt = ST_PRE;
            end
            default: nxt = ST_PRE;
        endcase
    end

    assign accept    = req_valid && req_ready;
    assign ref_ack   = (state_q == ST_IDLE) && (nxt == ST_CBR_CAS);
    assign wait_load = (nxt != state_q);

    always_comb begin
        unique case (nxt)
            ST_PRE:     wait_val = WCW'(T_RP - 1);
            ST_RCD:     wait_val = WCW'(T_RCD - 1);
            ST_CAS:     wait_val = WCW'(T_CAS - 1);
            ST_CBR_CAS: wait_val = WCW'(T_CSR - 1);
            ST_CBR_RAS: wait_val = WCW'(T_RAS_CBR - 1);
            default:    wait_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRE;
        end else begin
            state_q <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            row_q   <= req_row;
            col_q   <= req_col;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
        end
    end

    // cycles the row strobe has already been low in this activation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (ras_n) begin
            age_q <= '0;
        end else if (age_q != AGE_W'(T_RAS_MAX)) begin
            age_q <= age_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= (state_q == ST_CAS) && wait_done && !wr_q;
            if ((state_q == ST_CAS) && wait_done && !wr_q) begin
                rd_data_q <= dq_in;
            end
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign dq_out   = wdata_q;

    // memory pins as a function of the state
    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        oe_n  = 1'b1;
        dq_oe = 1'b0;
        addr  = '0;
        unique case (state_q)
            ST_ROW: begin
                addr = ADDR_W'(row_q);
            end
            ST_RCD: begin
                ras_n = 1'b0;
                addr  = ADDR_W'(row_q);
            end
            ST_COL: begin
                ras_n = 1'b0;
                addr  = ADDR_W'(col_q);
                we_n  = !wr_q;
                dq_oe = wr_q;
            end
            ST_CAS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                addr  = ADDR_W'(col_q);
                we_n  = !wr_q;
                dq_oe = wr_q;
                oe_n  = wr_q;
            end
            ST_PAGE: begin
                ras_n = 1'b0;
                addr  = ADDR_W'(col_q);
            end
            ST_CBR_CAS: begin
                cas_n = 1'b0;
            end
            ST_CBR_RAS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            default: begin
                ras_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fpm_seq_checker.sv
module fpm_seq_checker #(
    parameter int ADDR_W    = 13,
    parameter int T_RP      = 3,
    parameter int T_RAS_MAX = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] addr
);

    localparam int HW = $clog2(T_RP + 1);
    localparam int LW = $clog2(T_RAS_MAX + 1);

    logic [HW-1:0] hi_q;
    logic [LW-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (!ras_n) begin
                hi_q <= '0;
            end else if (hi_q != HW'(T_RP)) begin
                hi_q <= hi_q + 1'b1;
            end
            if (ras_n) begin
                lo_q <= '0;
            end else if (lo_q != LW'(T_RAS_MAX)) begin
                lo_q <= lo_q + 1'b1;
            end
        end
    end

    a_r7_ras_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_q >= HW'(T_RP)));

    a_r8_ras_low_max: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (lo_q < LW'(T_RAS_MAX)));

    a_r2_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n) |-> $stable(addr));

    a_r2_col_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !cas_n) |-> $stable(addr));

    a_r4_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !ras_n && !we_n) |-> ($past(we_n) == 1'b0));

    a_r10_cbr_we_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && !cas_n) |-> (we_n && !dq_oe));

    a_r10_cbr_ras_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> we_n);

    a_r13_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && !dq_oe));

    a_r13_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

bind fpm_dram_seq fpm_seq_checker #(
    .ADDR_W    (ADDR_W),
    .T_RP      (T_RP),
    .T_RAS_MAX (T_RAS_MAX)
) u_seq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dq_oe    (dq_oe),
    .rd_valid (rd_valid),
    .addr     (addr)
);

// File: tb/test_fpm_dram_seq.sv
module test_fpm_dram_seq;

    localparam int ROW_W      = 3;
    localparam int COL_W      = 4;
    localparam int DATA_W     = 4;
    localparam int T_RP       = 3;
    localparam int T_RCD      = 2;
    localparam int T_CAS      = 2;
    localparam int T_CSR      = 1;
    localparam int T_RAS_CBR  = 4;
    localparam int T_RAS_MAX  = 40;
    localparam int REF_PERIOD = 900;
    localparam int ADDR_W     = 4;
    localparam int ROWS       = 8;
    localparam int REF_IVL    = 100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] dq_out;
    logic [DATA_W-1:0] dq_in;

    always #5 clk = ~clk;

    fpm_dram_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RP(T_RP),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CSR(T_CSR), .T_RAS_CBR(T_RAS_CBR),
        .T_RAS_MAX(T_RAS_MAX), .REF_PERIOD(REF_PERIOD)
    ) i_fpm_dram_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [DATA_W-1:0] mem [int];
    logic [ROW_W-1:0]  m_row = '0;
    logic [COL_W-1:0]  m_col = '0;
    logic [DATA_W-1:0] rd_word = '0;
    logic p_ras = 1'b1, p_cas = 1'b1;
    int ras_falls = 0, cas_falls = 0, cbr_cnt = 0, cbr_bad = 0, cas_lead = 0;
    int lo_run = 0, max_lo = 0, hi_run = 0, min_hi = 1000, cas_lo_cnt = 0;
    int conflict = 0, last_cbr = 0, max_gap = 0, cyc = 0, rdy_bad = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            p_ras = 1'b1; p_cas = 1'b1; hi_run = 0; lo_run = 0; cas_lo_cnt = 0;
        end else begin
            if (!ras_n && p_ras) begin
                ras_falls++;
                if (hi_run < min_hi) min_hi = hi_run;
                if (!cas_n) begin
                    cbr_cnt++;
                    if (!we_n || dq_oe || cas_lead < T_CSR) cbr_bad++;
                    if (last_cbr != 0 && cyc - last_cbr > max_gap) max_gap = cyc - last_cbr;
                    last_cbr = cyc;
                end else begin
                    m_row = addr[ROW_W-1:0];
                end
            end
            if (!cas_n && p_cas && !ras_n && !p_ras) begin
                cas_falls++;
                m_col = addr[COL_W-1:0];
                if (!we_n) begin
                    if (!dq_oe) conflict++;
                    mem[int'({m_row, m_col})] = dq_out;
                end
                rd_word = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})] : '0;
            end
            if (!we_n && !oe_n) conflict++;
            if (ras_n) begin hi_run++; lo_run = 0; end
            else begin lo_run++; hi_run = 0; if (lo_run > max_lo) max_lo = lo_run; end
            if (!cas_n && ras_n) cas_lead++;
            else if (cas_n) cas_lead = 0;
            if (!cas_n) cas_lo_cnt++; else cas_lo_cnt = 0;
            p_ras = ras_n;
            p_cas = cas_n;
        end
    end

    // data is valid only after one full cycle of column strobe low
    assign dq_in = (!ras_n && !cas_n && we_n && !oe_n && cas_lo_cnt >= T_CAS - 1)
                   ? rd_word : '0;

    always @(negedge clk) begin
        if (rst_n && ras_n && !cas_n && req_ready) rdy_bad++;
    end

    // ---------------- scoreboard ----------------
    logic [DATA_W-1:0] shadow [int];
    logic [DATA_W-1:0] exp_q [$];

    always @(negedge clk) begin
        if (rst_n && rd_valid && !done_flag) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected rd_valid", int'(rd_data), -1);
            end else begin
                logic [DATA_W-1:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R3", "read data", int'(rd_data), int'(e));
            end
        end
    end

    // called at a negedge; returns just after the accepting posedge
    task automatic issue(input bit wr, input int row, input int col, input int d);
        int key;
        key       = int'({ROW_W'(row), COL_W'(col)});
        req_valid = 1'b1;
        req_write = wr;
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        req_wdata = DATA_W'(d);
        if (wr) shadow[key] = DATA_W'(d);
        else exp_q.push_back(shadow.exists(key) ? shadow[key] : '0);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_refresh();
        int c;
        c = cbr_cnt;
        while (cbr_cnt == c) @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        int r0, c0, k0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ras_n && cas_n && we_n && oe_n, "R1", "strobes idle in reset",
              int'({ras_n, cas_n, we_n, oe_n}), 15);
        check(!dq_oe && !rd_valid && !req_ready, "R1", "outputs quiet in reset",
              int'({dq_oe, rd_valid, req_ready}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_ready && ras_n, "R12", "not ready during first precharge",
              int'(req_ready), 0);

        // R2 / R4 / R5: write then page-hit write
        wait_refresh();
        r0 = ras_falls; c0 = cas_falls;
        issue(1, 1, 2, 4'hA);
        while (cas_falls == c0) @(negedge clk);
        check(m_row == 3'd1 && m_col == 4'd2, "R2", "latched row/col",
              int'({m_row, m_col}), int'({3'd1, 4'd2}));
        k0 = int'({3'd1, 4'd2});
        check(mem.exists(k0) && mem[k0] == 4'hA, "R4", "early write stored",
              mem.exists(k0) ? int'(mem[k0]) : -1, 10);
        issue(1, 1, 7, 4'h5);
        while (cas_falls < c0 + 2) @(negedge clk);
        check(ras_falls - r0 == 1, "R5", "row strobes for page-hit pair", ras_falls - r0, 1);
        check(cas_falls - c0 == 2, "R5", "column strobes for page-hit pair", cas_falls - c0, 2);
        issue(0, 1, 2, 0);
        issue(0, 1, 7, 0);
        drain();

        // R6: page miss
        wait_refresh();
        r0 = ras_falls;
        issue(1, 5, 3, 4'h6);
        issue(0, 1, 2, 0);
        drain();
        check(ras_falls - r0 == 2, "R6", "row strobes for page miss", ras_falls - r0, 2);

        // R3 / R4: pattern across all rows, then read back
        for (int r = 0; r < ROWS; r++) issue(1, r, (r * 5) % 16, (r * 3 + 1) % 16);
        for (int r = ROWS - 1; r >= 0; r--) issue(0, r, (r * 5) % 16, 0);
        for (int c = 0; c < 16; c += 3) issue(1, 6, c, 15 - c);
        for (int c = 0; c < 16; c += 3) issue(0, 6, c, 0);
        drain();
        check(exp_q.size() == 0, "R3", "all reads returned", exp_q.size(), 0);

        // R8: idle open page must close
        wait_refresh();
        issue(0, 2, 0, 0);
        repeat (T_RAS_MAX + 5) @(negedge clk);
        check(ras_n == 1'b1, "R8", "idle page closed", int'(ras_n), 1);
        drain();

        // R11: refresh breaks into a stream of page hits
        r0 = cbr_cnt;
        for (int i = 0; i < 70; i++) issue(0, 3, i % 16, 0);
        drain();
        check(cbr_cnt - r0 >= 2, "R11", "refreshes during page stream", cbr_cnt - r0, 2);

        // R9: coverage over one refresh period
        r0 = cbr_cnt;
        repeat (REF_PERIOD) @(negedge clk);
        check(cbr_cnt - r0 >= ROWS, "R9", "refreshes per period", cbr_cnt - r0, ROWS);
        check(max_gap <= 2 * REF_IVL, "R9", "largest refresh gap", max_gap, 2 * REF_IVL);

        // closing pin-level tallies
        check(cbr_cnt > 0 && cbr_bad == 0, "R10", "malformed refresh cycles", cbr_bad, 0);
        check(min_hi >= T_RP, "R7", "shortest row precharge", min_hi, T_RP);
        check(max_lo <= T_RAS_MAX, "R8", "longest row strobe low", max_lo, T_RAS_MAX);
        check(conflict == 0, "R13", "we/oe conflicts", conflict, 0);
        check(rdy_bad == 0, "R11", "ready during refresh", rdy_bad, 0);
        check(exp_q.size() == 0, "R3", "scoreboard empty", exp_q.size(), 0);
        finish_run();
    end

endmodule